// File: doc/BRIEF.md
# Sectored External Bus Interface

This block carries the data-memory accesses of a processor core that fall above the on-chip SRAM out to an external bus. The bus is multiplexed. In the first cycle of an access the block puts the low address byte on a shared address/data byte and raises an address latch enable. It then lowers a read or a write strobe. A separate group of pins carries the high address byte. While an access is in progress the core sees `ready` low and is stalled. It may present a new request only when `ready` is high.

The external address range is split into a lower and an upper sector. A 3-bit boundary field places the start of the upper sector at 0x2000 times the field value, and the value zero gives one sector that covers everything. Each sector has its own 2-bit wait code. Code 3 lengthens the strobe like code 2 and also inserts one idle cycle before the next address phase. Software can give some of the topmost high-address pins back to general use, and those pins are then not driven. An optional bus keeper holds the last value seen on the shared byte while nothing drives it.

Top module: `extbus_sectored`

## Requirements
- R1: A request is accepted only when `ready` is high, `ext_en` is 1 and `addr` is above INT_TOP (default 0x025F). Any other request is ignored: `ready` stays high, and `ale`, `rd_n` and `wr_n` stay idle.
- R2: In the cycle after acceptance, `ale` is 1 for exactly one cycle. During that cycle `ad_oe` is 1, `ad_out` equals `addr[7:0]` and `ah_out` equals `addr[15:8]`.
- R3: The strobe phase follows the address phase and lasts 1+w cycles, where w is 0, 1, 2 and 2 for wait codes 0, 1, 2 and 3. A read lowers only `rd_n` and a write lowers only `wr_n`, and the two are never low together.
- R4: With wait code 3, one extra cycle with both strobes high and `ale` low follows the strobe. `ready` is low from the address phase through the last busy cycle. While `ready` is high, `ale` is 0 and both strobes are 1.
- R5: When `bnd_sel` is 0, every access uses `wait_lo`. When `bnd_sel` = n > 0, an address at or above n*0x2000 uses `wait_hi` and a lower address uses `wait_lo`. The codes in use are the ones present when the request is accepted.
- R6: During a write strobe `ad_oe` is 1 and `ad_out` equals `wdata`. During a read strobe `ad_oe` is 0, and `rdata` takes the value of `ad_in` in the last strobe cycle. `rdata` keeps that value until the next read.
- R7: `ah_oe[i]` is 1 exactly when `ext_en` is 1 and i < 8 - `hi_rel`. The `hi_rel` topmost high-address pins are released.
- R8: While `ad_oe` is 0 and `keep_en` is 1, `ad_hold` is 1 and `ad_out` holds the last value on the shared byte, whether the block drove it or sampled it on a read. When `keep_en` is 0, `ad_hold` and an undriven `ad_out` are 0.
- R9: After reset `ready` is 1, `ale` is 0, both strobes are 1, `ad_oe` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en | input | 1 | Enables the external bus |
| keep_en | input | 1 | Enables the bus keeper on the shared byte |
| bnd_sel | input | 3 | Upper-sector start in units of 0x2000; 0 means a single sector |
| wait_lo | input | 2 | Wait code of the lower sector |
| wait_hi | input | 2 | Wait code of the upper sector |
| hi_rel | input | 3 | Number of topmost high-address pins released |
| req | input | 1 | Access request from the core |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | 16 | Data-space address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Data returned by the last external read |
| ready | output | 1 | High when idle; low stalls the core |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Value on the shared address/data byte |
| ad_oe | output | 1 | Strong drive enable for the shared byte |
| ad_hold | output | 1 | Weak keeper drive enable for the shared byte |
| ad_in | input | 8 | Value read back from the shared byte |
| ah_out | output | 8 | High address byte |
| ah_oe | output | 8 | Per-pin drive enable of the high address byte |

## Verification
Reads and writes are run with each of the four wait codes, in a single sector. The strobe lengths and the extra cycle of code 3 each give a different busy-cycle count, so a swapped code or a missing tail cycle shows up in the counts. Sector choice is tested on the two addresses on either side of a boundary, with different codes in the two sectors, and with a zero boundary at a high address. This separates an off-by-one boundary compare from a wrong selection. Requests below INT_TOP, requests at INT_TOP and requests made while the bus is disabled show that such requests are ignored. Several `hi_rel` values and a write followed by a read with the keeper on and off show the pin masking and what the keeper holds.

// File: rtl/extbus_pkg.sv
// Shared types and the wait-code decode of the sectored external bus.
// Assumes 2-bit wait codes; code 3 adds a tail cycle after the strobe.
package extbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_TAIL = 2'd3
    } bus_st_t;

    // Extra strobe cycles beyond the first for a wait code.
    function automatic logic [1:0] strobe_extra(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // Whether a wait code asks for an idle cycle after the strobe.
    function automatic logic wants_tail(input logic [1:0] code);
        return code == 2'd3;
    endfunction

endpackage

// File: rtl/extbus_sector_sel.sv
// Decides whether an address is external and which sector's wait code
// applies. Assumes the boundary field scales in steps of 2^(ADDR_W-BND_W).
module extbus_sector_sel #(
    parameter int          ADDR_W  = 16,
    parameter int          BND_W   = 3,
    parameter logic [15:0] INT_TOP = 16'h025F
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BND_W-1:0]  bnd,
    input  logic [1:0]        wait_lo,
    input  logic [1:0]        wait_hi,
    output logic              hit,
    output logic [1:0]        code
);
    localparam int SHIFT = ADDR_W - BND_W;

    logic [ADDR_W-1:0] upper_start;
    logic              in_upper;

    // Decode the external hit and the sector's wait code.
    always_comb begin
        upper_start = {bnd, {SHIFT{1'b0}}};
        in_upper    = (bnd != '0) && (addr >= upper_start);
        hit         = en && (addr > ADDR_W'(INT_TOP));
        code        = in_upper ? wait_hi : wait_lo;
    end
endmodule

// File: rtl/extbus_seq.sv
// Access sequencer: address phase, strobe phase of 1+w cycles, and an
// optional tail cycle. Assumes req is only honoured while ready is high.
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     hit,
    input  logic [1:0]               code,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ready,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     drv_oe,
    output logic [DATA_W-1:0]        drv_val,
    output logic                     cap,
    output logic [ADDR_W-DATA_W-1:0] ah_val,
    output logic [DATA_W-1:0]        rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    bus_st_t           st;
    logic [1:0]        cnt;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic              we_q;
    logic [1:0]        code_q;

    // State advance and capture of the request and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            a_q    <= '0;
            d_q    <= '0;
            we_q   <= 1'b0;
            code_q <= '0;
            rdata  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req && hit) begin
                    a_q    <= addr;
                    d_q    <= wdata;
                    we_q   <= we;
                    code_q <= code;
                    st     <= ST_ADDR;
                end
                ST_ADDR: begin
                    cnt <= strobe_extra(code_q);
                    st  <= ST_STRB;
                end
                ST_STRB: if (cnt == 2'd0) begin
                    if (!we_q) rdata <= ad_in;
                    st <= wants_tail(code_q) ? ST_TAIL : ST_IDLE;
                end else begin
                    cnt <= cnt - 2'd1;
                end
                ST_TAIL: st <= ST_IDLE;
            endcase
        end
    end

    // Bus-side outputs decoded from the current state.
    always_comb begin
        ready   = (st == ST_IDLE);
        ale     = (st == ST_ADDR);
        rd_n    = !((st == ST_STRB) && !we_q);
        wr_n    = !((st == ST_STRB) && we_q);
        drv_oe  = (st == ST_ADDR) || ((st == ST_STRB) && we_q);
        drv_val = (st == ST_ADDR) ? a_q[DATA_W-1:0] : d_q;
        cap     = (st == ST_STRB) && (cnt == 2'd0) && !we_q;
        ah_val  = a_q[ADDR_W-1:ADDR_W-HI_W];
    end

    a_r1_ignore_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !hit) |=> ready);
    a_r2_ale_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && hit) |=> (ale && !ready));
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (rd_n && wr_n && !ale));
    a_r6_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !drv_oe);
    a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(rdata));
endmodule

// File: rtl/extbus_pads.sv
// Pad-side view: bus keeper on the shared byte and per-pin enables of the
// high address byte. Assumes the keeper follows strong drives and read samples.
module extbus_pads #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8,
    parameter int REL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              keep_en,
    input  logic [REL_W-1:0]  hi_rel,
    input  logic              drv_oe,
    input  logic [DATA_W-1:0] drv_val,
    input  logic              cap,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [HI_W-1:0]   ah_val,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ad_hold,
    output logic [HI_W-1:0]   ah_out,
    output logic [HI_W-1:0]   ah_oe
);
    logic [DATA_W-1:0] kept;
    logic [REL_W:0]    drive_cnt;

    // Keeper register follows whatever last sat on the shared byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      kept <= '0;
        else if (drv_oe) kept <= drv_val;
        else if (cap)    kept <= ad_in;
    end

    // Shared-byte value and enables.
    always_comb begin
        ad_oe     = drv_oe;
        ad_hold   = keep_en && !drv_oe;
        ad_out    = drv_oe ? drv_val : (keep_en ? kept : '0);
        ah_out    = ah_val;
        drive_cnt = (REL_W+1)'(HI_W) - {1'b0, hi_rel};
    end

    for (genvar i = 0; i < HI_W; i++) begin : g_hi_pin
        assign ah_oe[i] = en && ((REL_W+1)'(i) < drive_cnt);
    end

    a_r8_keeper_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_oe && keep_en && $past(drv_oe) && $past(keep_en)) |-> (ad_out == $past(ad_out)));
    a_r8_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep_en && !drv_oe) |-> (ad_out == '0 && !ad_hold));
    a_r7_off_released: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (ah_oe == '0));
endmodule

// File: rtl/extbus_sectored.sv
// Top of the sectored external bus interface: sector decode, access
// sequencer and pad logic. Assumes a core that waits on ready.
module extbus_sectored #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int          BND_W   = 3,
    parameter logic [15:0] INT_TOP = 16'h025F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_en,
    input  logic                     keep_en,
    input  logic [BND_W-1:0]         bnd_sel,
    input  logic [1:0]               wait_lo,
    input  logic [1:0]               wait_hi,
    input  logic [2:0]               hi_rel,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     ready,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ad_hold,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic [ADDR_W-DATA_W-1:0] ah_oe
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              hit;
    logic [1:0]        code;
    logic              drv_oe;
    logic [DATA_W-1:0] drv_val;
    logic              cap;
    logic [HI_W-1:0]   ah_val;

    extbus_sector_sel #(.ADDR_W(ADDR_W), .BND_W(BND_W), .INT_TOP(INT_TOP)) u_sel (
        .en(ext_en), .addr(addr), .bnd(bnd_sel), .wait_lo(wait_lo),
        .wait_hi(wait_hi), .hit(hit), .code(code)
    );

    extbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .hit(hit), .code(code), .ad_in(ad_in),
        .ready(ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .drv_oe(drv_oe), .drv_val(drv_val), .cap(cap),
        .ah_val(ah_val), .rdata(rdata)
    );

    extbus_pads #(.DATA_W(DATA_W), .HI_W(HI_W), .REL_W(3)) u_pads (
        .clk(clk), .rst_n(rst_n), .en(ext_en), .keep_en(keep_en),
        .hi_rel(hi_rel), .drv_oe(drv_oe), .drv_val(drv_val), .cap(cap),
        .ad_in(ad_in), .ah_val(ah_val), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_hold(ad_hold), .ah_out(ah_out), .ah_oe(ah_oe)
    );
endmodule

// File: tb/test_extbus_sectored.sv
// Directed bench for the sectored external bus interface.
module test_extbus_sectored;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0, keep_en = 1'b0;
    logic [2:0]  bnd_sel = '0, hi_rel = '0;
    logic [1:0]  wait_lo = '0, wait_hi = '0;
    logic        req = 1'b0, we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, ad_in = '0;
    logic [7:0]  rdata, ad_out, ah_out, ah_oe;
    logic        ready, ale, rd_n, wr_n, ad_oe, ad_hold;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    extbus_sectored i_extbus_sectored (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .keep_en(keep_en),
        .bnd_sel(bnd_sel), .wait_lo(wait_lo), .wait_hi(wait_hi), .hi_rel(hi_rel),
        .req(req), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ready(ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_hold(ad_hold), .ad_in(ad_in), .ah_out(ah_out), .ah_oe(ah_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One external access; checks phases, lengths and data against the code.
    task automatic do_access(input bit w, input logic [15:0] a, input logic [7:0] d,
                             input logic [1:0] code);
        int busy = 0, strb = 0, tail = 0, ales = 0, bad_wd = 0;
        int ext = (code == 2'd3) ? 2 : int'(code);
        @(negedge clk);
        we = w; addr = a; wdata = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(ale === 1'b1, "R2 ale in first cycle", int'(ale), 1);
        chk(ad_out === a[7:0] && ad_oe === 1'b1, "R2 low address on shared byte", int'(ad_out), int'(a[7:0]));
        chk(ah_out === a[15:8], "R2 high address byte", int'(ah_out), int'(a[15:8]));
        for (int i = 0; i < 12; i++) begin
            if (ready) break;
            busy++;
            if (ale) ales++;
            if (w ? !wr_n : !rd_n) begin
                strb++;
                if (w && (ad_out !== d || ad_oe !== 1'b1)) bad_wd++;
                if (!w && ad_oe !== 1'b0) bad_wd++;
            end
            if (!ale && rd_n && wr_n) tail++;
            @(negedge clk);
        end
        chk(ales == 1, "R2 single ale cycle", ales, 1);
        chk(strb == 1 + ext, "R3 strobe length", strb, 1 + ext);
        chk(tail == ((code == 2'd3) ? 1 : 0), "R4 tail cycle", tail, (code == 2'd3) ? 1 : 0);
        chk(busy == 2 + ext + ((code == 2'd3) ? 1 : 0), "R4 busy cycles", busy,
            2 + ext + ((code == 2'd3) ? 1 : 0));
        chk(bad_wd == 0, "R6 data phase drive", bad_wd, 0);
        if (!w) chk(rdata === ad_in, "R6 read data", int'(rdata), int'(ad_in));
    endtask

    task automatic t_reset();
        chk(ready === 1'b1, "R9 ready after reset", int'(ready), 1);
        chk(ale === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1, "R9 strobes idle", int'({ale, rd_n, wr_n}), 3);
        chk(ad_oe === 1'b0 && rdata === 8'h00, "R9 bus released, rdata zero", int'({ad_oe, rdata}), 0);
    endtask

    // Requests that must be ignored: disabled bus, internal addresses.
    task automatic t_ignore();
        logic [15:0] list [3] = '{16'h8000, 16'h0100, 16'h025F};
        for (int k = 0; k < 3; k++) begin
            int act = 0;
            ext_en = (k != 0);
            @(negedge clk);
            addr = list[k]; we = 1'b0; req = 1'b1;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                req = 1'b0;
                if (!ready || ale || !rd_n || !wr_n) act++;
            end
            chk(act == 0, "R1 request ignored", act, 0);
        end
        ext_en = 1'b1;
    endtask

    // All four wait codes in a single sector, reads and writes.
    task automatic t_waits();
        bnd_sel = 3'd0;
        for (int c = 0; c < 4; c++) begin
            wait_lo = 2'(c);
            wait_hi = 2'(3 - c);
            ad_in = 8'h50 + 8'(c);
            do_access(1'b0, 16'h1234 + 16'(c), 8'h00, 2'(c));
            do_access(1'b1, 16'hC0DE, 8'h90 + 8'(c), 2'(c));
        end
    endtask

    // Boundary at 0x4000, different codes per sector; zero boundary at a high address.
    task automatic t_sectors();
        bnd_sel = 3'd2; wait_lo = 2'd0; wait_hi = 2'd3; ad_in = 8'h11;
        do_access(1'b0, 16'h3FFF, 8'h00, 2'd0); // R5 just below boundary
        do_access(1'b0, 16'h4000, 8'h00, 2'd3); // R5 at boundary
        bnd_sel = 3'd7; wait_lo = 2'd1; wait_hi = 2'd2;
        do_access(1'b1, 16'hE000, 8'h77, 2'd2); // R5 top sector
        bnd_sel = 3'd0;
        do_access(1'b1, 16'hF000, 8'h66, 2'd1); // R5 single sector uses lower code
    endtask

    task automatic t_hipins();
        logic [2:0] rels [3] = '{3'd0, 3'd3, 3'd7};
        for (int k = 0; k < 3; k++) begin
            logic [7:0] exp = 8'hFF >> rels[k];
            hi_rel = rels[k];
            @(negedge clk);
            chk(ah_oe === exp, "R7 high pin enables", int'(ah_oe), int'(exp));
        end
        ext_en = 1'b0;
        @(negedge clk);
        chk(ah_oe === 8'h00, "R7 disabled releases all", int'(ah_oe), 0);
        ext_en = 1'b1; hi_rel = 3'd0;
    endtask

    task automatic t_keeper();
        keep_en = 1'b1; wait_lo = 2'd0; bnd_sel = 3'd0;
        do_access(1'b1, 16'h2345, 8'hA5, 2'd0);
        chk(ad_out === 8'hA5 && ad_hold === 1'b1, "R8 keeper holds written byte", int'(ad_out), 'hA5);
        ad_in = 8'h3C;
        do_access(1'b0, 16'h2346, 8'h00, 2'd0);
        ad_in = 8'h00;
        @(negedge clk);
        chk(ad_out === 8'h3C, "R8 keeper holds read byte", int'(ad_out), 'h3C);
        keep_en = 1'b0;
        @(negedge clk);
        chk(ad_out === 8'h00 && ad_hold === 1'b0, "R8 keeper off", int'({ad_hold, ad_out}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore();
        t_waits();
        t_sectors();
        t_hipins();
        t_keeper();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule